// File: doc/BRIEF.md
# Sector ECC Read Sequencer

This block produces the ordered list of read commands that fetches one flash page sector by sector, so that an error-correction checker further down the path receives each 512-byte sector and then that sector's 13 parity bytes, with nothing in between. A single start pulse launches a sequence. With the pulse, the block captures three settings: the page class (large or small), the number of sectors and the bus width. It then emits commands under a valid/ready handshake. Each command carries an opcode, a column address and a byte length.

On large pages, each sector's parity sits in one spare-area group at a 16-byte stride. The first two spare bytes are left for the bad-block marker. A small page holds a single sector. Its parity is split into two spare groups that step around the two marker bytes. On a 16-bit bus, every spare group length is padded up to an even byte count. A one-cycle done pulse closes the sequence.

Top module: `sector_read_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start pulse, cmd_valid_o and done_o are both 0.
- R2: The main command of sector s has opcode 0, column s*512 and length 512, whatever the bus width.
- R3: On a large page, the main command of sector s is followed at once, with no other command between, by one spare command with opcode 1, column 2+16*s and length 13 on an 8-bit bus.
- R4: On a small page, exactly three commands are issued: main (column 0, length 512), spare (column 0, length 4) and spare (column 6, length 9 on an 8-bit bus). The sector count input is ignored.
- R5: When wide_bus_i was 1 at start, each odd spare length is rounded up to the next even value (13 becomes 14, 9 becomes 10, and 4 stays 4).
- R6: On a large page, a sect_cnt_i value of n (3 bits) gives n+1 sectors, so the sequence has 2*(n+1) commands.
- R7: While cmd_valid_o is 1 and cmd_ready_i is 0, the opcode, column and length hold steady. A command is consumed only in a cycle where both are 1.
- R8: done_o is 1 for exactly one cycle, the cycle after the last spare command is accepted. cmd_valid_o is 0 in that cycle and afterwards.
- R9: A start pulse during a sequence is ignored. The settings are captured only when start is accepted, so later changes on the setting inputs do not affect the running sequence.
- R10: On a large page, no spare command addresses spare columns 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| large_page_i | input | 1 | 1 = large page, 0 = small 512-byte page |
| sect_cnt_i | input | 3 | Sector count minus one (large page only) |
| wide_bus_i | input | 1 | 1 = 16-bit flash bus |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Downstream accepts command |
| cmd_op_o | output | 1 | 0 = read main area, 1 = read spare area |
| cmd_col_o | output | 13 | Column address (main offset or spare offset) |
| cmd_len_o | output | 10 | Byte length of the read |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A corrupted sector counter or group index shows at the ports on the next presented command, as a wrong column or a wrong sector-to-parity pairing. A wrong state transition shows as a missing or extra spare command, or as a done pulse early, late or missing. Each command is compared in every cycle it is presented, including stalled cycles, so an error appears within one cycle of its cause. The sweep covers every sector count on both bus widths and both page classes, under several stall patterns. It also checks that the captured settings and a mid-run start pulse leave the running sequence alone.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;
  typedef enum logic {
    OP_MAIN  = 1'b0,
    OP_SPARE = 1'b1
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MAIN   = 3'd1,
    ST_SPARE0 = 3'd2,
    ST_SPARE1 = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/sector_seq_ctrl.sv
module sector_seq_ctrl
  import sector_seq_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              large_i,
  input  logic [SECT_W-1:0] cnt_i,
  input  logic              wide_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              is_main_o,
  output logic              grp_o,
  output logic [SECT_W-1:0] sect_o,
  output logic              large_q_o,
  output logic              wide_q_o,
  output logic              done_o
);
  seq_state_e        state_q, state_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [SECT_W-1:0] last_q;
  logic              large_q, wide_q;
  logic              cfg_en, fire;

  assign cfg_en = (state_q == ST_IDLE) && start_i;
  assign fire   = valid_o && ready_i;

  always_comb begin
    state_d = state_q;
    sect_d  = sect_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_MAIN;
        sect_d  = '0;
      end
      ST_MAIN: if (fire) state_d = ST_SPARE0;
      ST_SPARE0: if (fire) begin
        if (!large_q)            state_d = ST_SPARE1;
        else if (sect_q == last_q) state_d = ST_DONE;
        else begin
          state_d = ST_MAIN;
          sect_d  = sect_q + SECT_W'(1);
        end
      end
      ST_SPARE1: if (fire) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sect_q  <= '0;
    end else begin
      state_q <= state_d;
      sect_q  <= sect_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      large_q <= 1'b0;
      wide_q  <= 1'b0;
      last_q  <= '0;
    end else if (cfg_en) begin
      large_q <= large_i;
      wide_q  <= wide_i;
      last_q  <= large_i ? cnt_i : '0;
    end
  end

  assign valid_o   = (state_q == ST_MAIN) || (state_q == ST_SPARE0) ||
                     (state_q == ST_SPARE1);
  assign is_main_o = (state_q == ST_MAIN);
  assign grp_o     = (state_q == ST_SPARE1);
  assign sect_o    = sect_q;
  assign large_q_o = large_q;
  assign wide_q_o  = wide_q;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/sector_seq_layout.sv
module sector_seq_layout #(
  parameter int SECT_W       = 3,
  parameter int COL_W        = 13,
  parameter int LEN_W        = 10,
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int GROUP_BASE   = 2,
  parameter int GROUP_STRIDE = 16,
  parameter int SP_HEAD      = 4,
  parameter int MARK_BYTES   = 2
) (
  input  logic              is_main_i,
  input  logic              large_i,
  input  logic              grp_i,
  input  logic              wide_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [COL_W-1:0]  col_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int SECT_SH = $clog2(SECTOR_BYTES);
  localparam int SP_TAIL = ECC_BYTES - SP_HEAD;
  localparam int SP_OFF2 = SP_HEAD + MARK_BYTES;

  logic [LEN_W-1:0] raw_len;

  always_comb begin
    if (is_main_i) begin
      col_o   = COL_W'(sect_i) << SECT_SH;
      raw_len = LEN_W'(SECTOR_BYTES);
    end else if (large_i) begin
      col_o   = COL_W'(GROUP_BASE) + COL_W'(GROUP_STRIDE) * COL_W'(sect_i);
      raw_len = LEN_W'(ECC_BYTES);
    end else if (!grp_i) begin
      col_o   = '0;
      raw_len = LEN_W'(SP_HEAD);
    end else begin
      col_o   = COL_W'(SP_OFF2);
      raw_len = LEN_W'(SP_TAIL);
    end
    len_o = raw_len + LEN_W'(wide_i & raw_len[0]);
  end
endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq #(
  parameter int MAX_SECT     = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int SECT_W       = $clog2(MAX_SECT),
  parameter int COL_W        = $clog2(MAX_SECT * SECTOR_BYTES) + 1,
  parameter int LEN_W        = $clog2(SECTOR_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              large_page_i,
  input  logic [SECT_W-1:0] sect_cnt_i,
  input  logic              wide_bus_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_op_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              done_o
);
  logic              rst_meta, rst_sync;
  logic              is_main, grp, cfg_large, cfg_wide;
  logic [SECT_W-1:0] sect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sector_seq_ctrl #(.SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start_i(start_i), .large_i(large_page_i),
    .cnt_i(sect_cnt_i), .wide_i(wide_bus_i), .ready_i(cmd_ready_i),
    .valid_o(cmd_valid_o), .is_main_o(is_main), .grp_o(grp), .sect_o(sect),
    .large_q_o(cfg_large), .wide_q_o(cfg_wide), .done_o(done_o)
  );

  sector_seq_layout #(
    .SECT_W(SECT_W), .COL_W(COL_W), .LEN_W(LEN_W),
    .SECTOR_BYTES(SECTOR_BYTES), .ECC_BYTES(ECC_BYTES)
  ) u_layout (
    .is_main_i(is_main), .large_i(cfg_large), .grp_i(grp), .wide_i(cfg_wide),
    .sect_i(sect), .col_o(cmd_col_o), .len_o(cmd_len_o)
  );

  assign cmd_op_o = ~is_main;
endmodule

// File: rtl/sector_seq_chk.sv
module sector_seq_chk #(
  parameter int COL_W = 13,
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_op,
  input logic [COL_W-1:0] cmd_col,
  input logic [LEN_W-1:0] cmd_len,
  input logic             done,
  input logic             large_q
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
    $stable(cmd_col) && $stable(cmd_len));
  // R3
  parity_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_op |=> cmd_valid && cmd_op);
  // R2
  main_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op |-> cmd_len == LEN_W'(512) && cmd_col[8:0] == 9'd0);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
  // R10
  marker_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op && large_q |-> cmd_col >= COL_W'(2));
endmodule

bind sector_read_seq sector_seq_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_o), .cmd_ready(cmd_ready_i),
  .cmd_op(cmd_op_o), .cmd_col(cmd_col_o), .cmd_len(cmd_len_o),
  .done(done_o), .large_q(cfg_large)
);

// File: tb/sector_read_seq_bench.sv
`timescale 1ns/1ps
module sector_read_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, large_page_i, wide_bus_i, cmd_ready_i;
  logic [2:0]  sect_cnt_i;
  logic        cmd_valid_o, cmd_op_o, done_o;
  logic [12:0] cmd_col_o;
  logic [9:0]  cmd_len_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sector_read_seq u_sector_read_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .large_page_i(large_page_i),
    .sect_cnt_i(sect_cnt_i), .wide_bus_i(wide_bus_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_col_o(cmd_col_o),
    .cmd_len_o(cmd_len_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input bit lg, input bit wd, input int cnt,
                         input int pat, input bit poke);
    int  total;
    int  k = 0;
    int  cyc = 0;
    bit  prev_last = 0;
    bit  prev_stall = 0;
    bit  fin = 0;
    bit  rdy;
    int  e_op, e_col, e_len, sec;
    string tag;
    total = lg ? 2 * (cnt + 1) : 3;
    @(negedge clk);
    large_page_i = lg; wide_bus_i = wd; sect_cnt_i = cnt[2:0];
    start_i = 1'b1; cmd_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    large_page_i = ~lg; wide_bus_i = ~wd; sect_cnt_i = ~cnt[2:0];
    while (!fin && cyc < 400) begin
      if (done_o) begin
        chk(prev_last, "R8 done after last accept", 0, 1);
        chk(k == total, "R6 command count", k, total);
        chk(!cmd_valid_o, "R8 no valid with done", 1, 0);
        fin = 1;
      end else begin
        if (prev_last) chk(0, "R8 done missing", 0, 1);
        chk(cmd_valid_o == (k < total), "R9 valid while busy", cmd_valid_o, k < total);
        if (cmd_valid_o && k < total) begin
          if (lg) begin
            sec = k / 2;
            if (k % 2 == 0) begin e_op = 0; e_col = sec * 512; e_len = 512; tag = "R2 main"; end
            else begin e_op = 1; e_col = 2 + 16 * sec; e_len = wd ? 14 : 13; tag = wd ? "R5 large spare" : "R3 large spare"; end
          end else begin
            case (k)
              0: begin e_op = 0; e_col = 0; e_len = 512; tag = "R2 main"; end
              1: begin e_op = 1; e_col = 0; e_len = 4; tag = "R4 small spare head"; end
              default: begin e_op = 1; e_col = 6; e_len = wd ? 10 : 9; tag = wd ? "R5 small spare tail" : "R4 small spare tail"; end
            endcase
          end
          if (prev_stall) tag = {"R7 held ", tag};
          chk(cmd_op_o == e_op[0], {tag, " op"}, cmd_op_o, e_op);
          chk(cmd_col_o == e_col[12:0], {tag, " col"}, cmd_col_o, e_col);
          chk(cmd_len_o == e_len[9:0], {tag, " len"}, cmd_len_o, e_len);
          if (lg && e_op == 1) chk(cmd_col_o >= 2, "R10 marker skip", cmd_col_o, 2);
        end
        rdy = (pat == 0) ? 1'b1 : ((cyc % (pat + 1)) != 0);
        start_i = poke && (k == 1);
        cmd_ready_i = rdy;
        prev_stall = cmd_valid_o && !rdy;
        prev_last = rdy && cmd_valid_o && (k == total - 1);
        if (rdy && cmd_valid_o) k++;
      end
      cyc++;
      @(negedge clk);
    end
    chk(fin, "R8 sequence finished", fin, 1);
    start_i = 1'b0; cmd_ready_i = 1'b1;
    chk(!done_o && !cmd_valid_o, "R8 pulse one cycle", done_o, 0);
    @(negedge clk);
    chk(!cmd_valid_o, "R9 no restart after poke", cmd_valid_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; large_page_i = 1'b0; wide_bus_i = 1'b0;
    sect_cnt_i = 3'd0; cmd_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !done_o, "R1 reset idle", cmd_valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmd_valid_o && !done_o, "R1 idle after release", cmd_valid_o, 0);
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 8; c++) run_seq(1'b1, w[0], c, p, c[0]);
        for (int c = 0; c < 8; c += 5) run_seq(1'b0, w[0], c, p, 1'b1);
      end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule